// File: doc/BRIEF.md
# Converter Self-Calibration Sequencer

This block measures, averages, stores and applies correction codes for the upper bits of a successive-approximation converter. After a reset release, once the power-good input has been held high for a programmable settle time, it runs one calibration pass. The pass takes each upper-array entry in turn. For each entry it repeats a small binary-search measurement a power-of-two number of times, steered by a comparator decision bit from the analog side. It sums the signed results and stores the sum shifted right as that entry's correction code.

While the pass runs, `busy` is high and convert requests are dropped; they are not queued. Afterwards the block turns accepted convert requests into one-cycle start pulses. It also reports, one cycle after any trial pattern of the upper bits, the signed sum of the codes of the bits that are set. A sleep input gates conversions and freezes the sequencer. Stored codes survive sleep and need no refresh.

Top module: `sar_cal_sequencer`

## Requirements
- R1: There are `N_CAL` correction entries (default 10). Entry i belongs to bit i of `trial_hi` and is packed in `code_file[i*CW +: CW]` as a signed `CW`-bit value.
- R2: One clock edge after `trial_hi` is applied, `corr_sum` equals the signed sum of the entries whose `trial_hi` bit is 1, or 0 if none is set.
- R3: After reset release, calibration starts only after `pwr_good` has been sampled high on `POR_CYC` consecutive edges. A low sample restarts the count. Until calibration starts, `cal_probe` is 0.
- R4: While `rst_n` is low (synchronous), `busy` is 1, `conv_go` is 0 and every entry reads 0. Each release starts a new calibration.
- R5: Each measurement is a `CW`-step binary search, MSB first, one step per edge. `cal_probe` shows the bits kept so far plus the bit under test, so its first value is only the MSB set. `cmp_keep`=1 keeps the bit under test. The final offset-binary value minus 2^(CW-1) is the signed measurement.
- R6: Entries are calibrated in index order 0 to `N_CAL`-1, and `cal_sel` shows the entry being measured. Each entry stores floor(sum of 2^AVG_LOG2 signed measurements / 2^AVG_LOG2).
- R7: With `pwr_good` high from release, `busy` falls exactly POR_CYC+1+N_CAL*2^AVG_LOG2*CW edges after release. Once low, it stays low until the next reset.
- R8: `conv_req` sampled while `busy` is high is ignored and not queued. When the block is idle, `conv_go` is 1 for one cycle, one edge after each sampled request.
- R9: While `sleep` is high, `conv_req` is ignored and the stored entries do not change. After `sleep` falls, conversions are accepted again with no recalibration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; release starts calibration |
| pwr_good | input | 1 | Supply-settled indication feeding the start delay |
| sleep | input | 1 | Low-power hold: blocks conversions, freezes sequencer |
| conv_req | input | 1 | Convert request |
| cmp_keep | input | 1 | Comparator decision for the current search step |
| trial_hi | input | N_CAL | Upper bits of the present trial code |
| busy | output | 1 | High from reset until calibration completes |
| conv_go | output | 1 | One-cycle conversion start pulse |
| cal_sel | output | clog2(N_CAL) | Entry under measurement |
| cal_probe | output | CW | Search candidate under comparison |
| code_file | output | N_CAL*CW | All stored signed correction codes |
| corr_sum | output | CW+clog2(N_CAL) | Signed sum of active entries |

## Verification
`corr_sum` and `conv_go` are due one edge after their input is applied, so the bench drives inputs on a falling edge and samples on the next falling edge. Calibration timing is counted edge by edge from the release. The bench samples `cal_probe` just after the POR_CYC-th edge, where it is still 0, and just after the next edge, where it shows the MSB. It samples `busy` after the last search edge and after the edge that follows, expecting 1 and then 0. The comparator model answers from the live probe at each falling edge. Every stored code is then compared with an average computed arithmetically from the bench's own target values, over several calibrations and a full sweep of the upper-bit patterns.

// File: rtl/sar_cal_pkg.sv
// Shared types for the calibration sequencer.
package sar_cal_pkg;
    typedef enum logic [1:0] {
        ST_SETTLE = 2'd0,   // waiting for supply settle time
        ST_MEAS   = 2'd1,   // running the calibration pass
        ST_READY  = 2'd2    // calibrated, accepting conversions
    } cal_state_t;
endpackage

// File: rtl/sar_cal_settle.sv
// Settle timer: counts consecutive edges with pwr_good high and saturates
// at POR_CYC. Assumes POR_CYC >= 1; any low sample clears the count.
module sar_cal_settle #(
    parameter int POR_CYC = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good,
    output logic settled
);
    localparam int TW = $clog2(POR_CYC + 1);

    logic [TW-1:0] run_cnt;

    // count good samples, restart on any low sample
    always_ff @(posedge clk) begin
        if (!rst_n)              run_cnt <= '0;
        else if (!pwr_good)      run_cnt <= '0;
        else if (!settled)       run_cnt <= run_cnt + 1'b1;
    end

    assign settled = (run_cnt == TW'(POR_CYC));

    AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_good) |=> !settled); // R3
endmodule

// File: rtl/sar_cal_meas.sv
// Measurement engine: one binary-search step per enabled edge, MSB first,
// 2^AVG_LOG2 searches per entry, signed accumulation and averaging by shift.
// Assumes CW >= 2. "done" marks the final step of an entry's last search.
module sar_cal_meas #(
    parameter int CW       = 11,
    parameter int AVG_LOG2 = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 step,
    input  logic                 keep,
    output logic [CW-1:0]        probe,
    output logic                 done,
    output logic signed [CW-1:0] avg
);
    localparam int BPW  = $clog2(CW);
    localparam int RW   = (AVG_LOG2 > 0) ? AVG_LOG2 : 1;
    localparam int REPS = 1 << AVG_LOG2;
    localparam int AW   = CW + AVG_LOG2;

    logic [CW-1:0]        kept_q, kept_d;
    logic [BPW-1:0]       pos_q;
    logic [RW-1:0]        rep_q;
    logic signed [AW-1:0] acc_q, acc_d;
    logic signed [CW-1:0] meas_s;
    logic                 last_step, last_rep;

    // candidate, decision and signed accumulation for this step
    always_comb begin
        probe     = kept_q | (CW'(1) << pos_q);
        kept_d    = keep ? probe : kept_q;
        meas_s    = $signed(kept_d ^ (CW'(1) << (CW - 1)));
        acc_d     = acc_q + AW'(meas_s);
        last_step = (pos_q == '0);
        last_rep  = (rep_q == RW'(REPS - 1));
        done      = step && last_step && last_rep;
        avg       = CW'(acc_d >>> AVG_LOG2);
    end

    // search position, repeat count and accumulator sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kept_q <= '0;
            pos_q  <= BPW'(CW - 1);
            rep_q  <= '0;
            acc_q  <= '0;
        end else if (step) begin
            if (last_step) begin
                kept_q <= '0;
                pos_q  <= BPW'(CW - 1);
                rep_q  <= last_rep ? '0 : rep_q + 1'b1;
                acc_q  <= last_rep ? '0 : acc_d;
            end else begin
                kept_q <= kept_d;
                pos_q  <= pos_q - 1'b1;
            end
        end
    end

    AST_KEPT_BITS_STAY: assert property (@(posedge clk) disable iff (!rst_n)
        (step && keep && !last_step) |=> ((probe & $past(probe)) == $past(probe))); // R5
endmodule

// File: rtl/sar_cal_store.sv
// Correction-code file: N_CAL signed entries written by the sequencer, and a
// registered signed sum of the entries whose trial bit is set.
module sar_cal_store #(
    parameter int N_CAL = 10,
    parameter int CW    = 11
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [$clog2(N_CAL)-1:0]   widx,
    input  logic signed [CW-1:0]       wdata,
    input  logic [N_CAL-1:0]           trial_hi,
    output logic [N_CAL*CW-1:0]        code_file,
    output logic signed [CW+$clog2(N_CAL)-1:0] corr_sum
);
    localparam int SW = CW + $clog2(N_CAL);

    logic signed [CW-1:0] codes [N_CAL];
    logic signed [SW-1:0] sum_d;

    // entry storage, cleared by reset, written once per calibrated entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_CAL; i++) codes[i] <= '0;
        end else if (we) begin
            codes[widx] <= wdata;
        end
    end

    genvar g;
    generate
        for (g = 0; g < N_CAL; g++) begin : g_pack
            assign code_file[g*CW +: CW] = codes[g];
        end
    endgenerate

    // signed sum of the entries selected by the trial bits
    always_comb begin
        sum_d = '0;
        for (int i = 0; i < N_CAL; i++)
            if (trial_hi[i]) sum_d = sum_d + SW'(codes[i]);
    end

    // register the correction word
    always_ff @(posedge clk) begin
        if (!rst_n) corr_sum <= '0;
        else        corr_sum <= sum_d;
    end

    AST_CODES_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(code_file)); // R9
    AST_NO_BITS_NO_CORR: assert property (@(posedge clk) disable iff (!rst_n)
        (trial_hi == '0) |=> (corr_sum == '0)); // R2
endmodule

// File: rtl/sar_cal_sequencer.sv
// Top of the calibration sequencer: settle delay, calibration pass over all
// upper-array entries, then conversion gating and correction output.
// Assumes N_CAL >= 2, CW >= 2, POR_CYC >= 1; the analog side answers
// cmp_keep for the cal_probe shown during the same cycle.
module sar_cal_sequencer
    import sar_cal_pkg::*;
#(
    parameter int N_CAL    = 10,
    parameter int CW       = 11,
    parameter int AVG_LOG2 = 7,
    parameter int POR_CYC  = 64
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              pwr_good,
    input  logic                              sleep,
    input  logic                              conv_req,
    input  logic                              cmp_keep,
    input  logic [N_CAL-1:0]                  trial_hi,
    output logic                              busy,
    output logic                              conv_go,
    output logic [$clog2(N_CAL)-1:0]          cal_sel,
    output logic [CW-1:0]                     cal_probe,
    output logic [N_CAL*CW-1:0]               code_file,
    output logic signed [CW+$clog2(N_CAL)-1:0] corr_sum
);
    localparam int SELW = $clog2(N_CAL);

    cal_state_t           state_q;
    logic [SELW-1:0]      ent_q;
    logic                 settled, step, entry_done;
    logic [CW-1:0]        probe_raw;
    logic signed [CW-1:0] avg_code;

    sar_cal_settle #(.POR_CYC(POR_CYC)) u_settle (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .settled(settled));

    assign step = (state_q == ST_MEAS) && !sleep;

    sar_cal_meas #(.CW(CW), .AVG_LOG2(AVG_LOG2)) u_meas (
        .clk(clk), .rst_n(rst_n), .step(step), .keep(cmp_keep),
        .probe(probe_raw), .done(entry_done), .avg(avg_code));

    sar_cal_store #(.N_CAL(N_CAL), .CW(CW)) u_store (
        .clk(clk), .rst_n(rst_n), .we(entry_done), .widx(ent_q),
        .wdata(avg_code), .trial_hi(trial_hi),
        .code_file(code_file), .corr_sum(corr_sum));

    // phase control and entry index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SETTLE;
            ent_q   <= '0;
        end else begin
            case (state_q)
                ST_SETTLE: if (settled && !sleep) state_q <= ST_MEAS;
                ST_MEAS: if (entry_done) begin
                    if (ent_q == SELW'(N_CAL - 1)) state_q <= ST_READY;
                    else                           ent_q   <= ent_q + 1'b1;
                end
                default: state_q <= state_q;
            endcase
        end
    end

    // conversion start pulse, only when calibrated and awake
    always_ff @(posedge clk) begin
        if (!rst_n) conv_go <= 1'b0;
        else        conv_go <= (state_q == ST_READY) && conv_req && !sleep;
    end

    assign busy      = (state_q != ST_READY);
    assign cal_sel   = ent_q;
    assign cal_probe = (state_q == ST_MEAS) ? probe_raw : '0;

    AST_GO_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_go |-> !busy); // R8
    AST_BUSY_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> busy); // R4
    AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> !busy); // R7
    AST_GO_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        conv_go |-> $past(conv_req)); // R8
endmodule

// File: tb/tb_sar_cal_sequencer.sv
module tb_sar_cal_sequencer;
    localparam int N   = 4;
    localparam int CW  = 4;
    localparam int AVG = 2;
    localparam int POR = 5;
    localparam int REPS = 1 << AVG;
    localparam int TOT  = N * REPS * CW;
    localparam int SW   = CW + $clog2(N);

    logic clk = 1'b0;
    logic rst_n, pwr_good, sleep, conv_req, cmp_keep;
    logic [N-1:0] trial_hi;
    logic busy, conv_go;
    logic [$clog2(N)-1:0] cal_sel;
    logic [CW-1:0] cal_probe;
    logic [N*CW-1:0] code_file;
    logic signed [SW-1:0] corr_sum;

    int checks = 0;
    int errors = 0;
    int kk = 0;
    int mcount = 0;

    always #4 clk = ~clk;

    sar_cal_sequencer #(.N_CAL(N), .CW(CW), .AVG_LOG2(AVG), .POR_CYC(POR)) dut (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .sleep(sleep),
        .conv_req(conv_req), .cmp_keep(cmp_keep), .trial_hi(trial_hi),
        .busy(busy), .conv_go(conv_go), .cal_sel(cal_sel), .cal_probe(cal_probe),
        .code_file(code_file), .corr_sum(corr_sum));

    // analog target for run k, entry s, repeat r (offset binary)
    function automatic int tgt(int k, int s, int r);
        return ((k * 5 + s * 3) % 13) + r;
    endfunction

    // expected stored code: floor of the mean of signed measurements
    function automatic int exp_code(int k, int s);
        int sum = 0;
        for (int r = 0; r < REPS; r++) sum += tgt(k, s, r) - (1 << (CW - 1));
        return sum >>> AVG;
    endfunction

    function automatic int field(int i);
        logic signed [CW-1:0] v;
        v = code_file[i*CW +: CW];
        return int'(v);
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // comparator model: counts searches by their first probe, answers probe <= target
    always @(negedge clk) begin
        int rep;
        if (!rst_n) mcount = 0;
        else if (cal_probe == 4'b1000) mcount++;
        rep = (mcount > 0) ? (mcount - 1) % REPS : 0;
        cmp_keep = (int'(cal_probe) <= tgt(kk, int'(cal_sel), rep));
    end

    // one calibration from a release at the last negedge, pwr_good high
    task automatic run_cal();
        repeat (POR) @(posedge clk);
        @(negedge clk);
        chk("R3 probe idle before settle", int'(cal_probe), 0);
        @(posedge clk); @(negedge clk);
        chk("R5 first probe MSB only", int'(cal_probe), 8);
        chk("R6 first entry index", int'(cal_sel), 0);
        conv_req = 1'b1;
        repeat (TOT - 1) @(posedge clk);
        @(negedge clk);
        chk("R7 busy on last step", int'(busy), 1);
        chk("R8 no go while busy", int'(conv_go), 0);
        conv_req = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R7 busy falls on time", int'(busy), 0);
        @(posedge clk); @(negedge clk);
        chk("R8 busy request not queued", int'(conv_go), 0);
        for (int s = 0; s < N; s++)
            chk($sformatf("R6 entry %0d code", s), field(s), exp_code(kk, s));
    endtask

    task automatic sweep_corr();
        for (int u = 0; u < (1 << N); u++) begin
            int e = 0;
            trial_hi = N'(u);
            for (int i = 0; i < N; i++) if (u[i]) e += exp_code(kk, i);
            @(negedge clk);
            chk($sformatf("R2 corr pattern %0d", u), int'(corr_sum), e);
        end
    endtask

    initial begin
        #2_000_000;
        checks++; errors++;
        $display("FAIL watchdog R7 actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; pwr_good = 1'b0; sleep = 1'b0; conv_req = 1'b0;
        trial_hi = '0; cmp_keep = 1'b0;
        repeat (3) @(negedge clk);
        chk("R4 busy in reset", int'(busy), 1);
        chk("R4 no go in reset", int'(conv_go), 0);
        chk("R4 codes cleared", int'(code_file), 0);

        // R3: power not good, then a short good window that is broken
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        chk("R3 busy without power good", int'(busy), 1);
        chk("R3 no probe without power good", int'(cal_probe), 0);
        pwr_good = 1'b1;
        repeat (POR - 1) @(negedge clk);
        pwr_good = 1'b0;
        repeat (3) @(negedge clk);
        chk("R3 broken window no start", int'(cal_probe), 0);
        pwr_good = 1'b1;
        kk = 0;
        run_cal();
        sweep_corr();

        for (int k = 1; k < 4; k++) begin
            rst_n = 1'b0;
            @(negedge clk); @(negedge clk);
            chk("R4 reset clears codes", int'(code_file), 0);
            chk("R4 reset raises busy", int'(busy), 1);
            kk = k;
            rst_n = 1'b1;
            run_cal();
            sweep_corr();
        end

        // R1: entry 2 alone lands in its own field and its own trial bit
        trial_hi = 4'b0100;
        @(negedge clk);
        chk("R1 single entry mapping", int'(corr_sum), field(2));

        // R8 accepted request
        conv_req = 1'b1;
        @(negedge clk);
        chk("R8 go after request", int'(conv_go), 1);
        conv_req = 1'b0;
        @(negedge clk);
        chk("R8 go is one cycle", int'(conv_go), 0);

        // R9 sleep blocks requests, keeps codes
        sleep = 1'b1; conv_req = 1'b1;
        repeat (4) @(negedge clk);
        chk("R9 no go while asleep", int'(conv_go), 0);
        for (int s = 0; s < N; s++)
            chk("R9 code retained", field(s), exp_code(kk, s));
        chk("R9 still calibrated", int'(busy), 0);
        sleep = 1'b0;
        @(negedge clk);
        chk("R9 go after wake", int'(conv_go), 1);
        conv_req = 1'b0;
        @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule